// File: doc/BRIEF.md
# Serial Flash Identification and Status Front End

This block is the serial-side controller of a small flash slave. The part stays idle while its active-low select is high. A falling select opens a sequence. The first eight serial bits form an opcode, and the block decodes it into one of three operations:

- An identification read. It takes an address field and then streams the two fixed identity bytes, chosen by the lowest address bit.
- A status read. It repeats the status byte for as long as the part stays selected.
- A status write. It loads the software protection bits and a lock bit, subject to a write-protect pin.

A hold pin lets the host pause a sequence mid-stream without deselecting the part. The block runs directly on the serial clock. The select line acts as an asynchronous clear for the sequence state. The status register is cleared only by the block reset. Host clocking with the clock idling low or idling high both work without configuration, because only the edge direction matters.

Top module: `spi_id_slave`

## Requirements
- R1: With the serial clock idling low or idling high, `si` is captured on each rising `sck` edge and `so` changes only after a falling edge; bytes travel most significant bit first in both directions.
- R2: Opcode 0x90 followed by three address bytes (most significant first) starts an identity stream: each following byte is 0xBF when the current address is even and 0x49 when it is odd, and the address advances by one after every byte (wrapping from all ones to zero).
- R3: Opcode 0x05 returns the status byte on every following byte slot; status bits other than bit 7 and bits 3:2 always read 0.
- R4: `so_oe` is 0 while `cs_n` is high and during every opcode and address bit; it becomes 1 from the falling edge that presents the first data bit of a read.
- R5: While `hold_n` is low, `sck` edges change no state and `so_oe` is 0; once `hold_n` is high again the same pending bit is driven and the sequence continues where it stopped.
- R6: Opcode 0x01 followed by one data byte loads status bit 7 (lock) and bits 3:2 (protect) from that byte after its eighth bit; further bytes in the same selection have no effect.
- R7: A status write whose data byte is cut short by `cs_n` rising leaves the status unchanged.
- R8: When `wp_n` is 0 and the lock bit is 1, a status write is ignored; with `wp_n` at 1, or with the lock bit at 0, it is accepted.
- R9: Any opcode other than 0x90, 0x05 and 0x01 keeps `so_oe` at 0 and makes all further bytes up to the next rise of `cs_n` ineffective.
- R10: Raising `cs_n` at any bit aborts the command, and the next selection decodes its first byte as an opcode.
- R11: With `rst_n` low the status is 0 and `so_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of all state including status |
| cs_n | input | 1 | Active-low select; high clears the sequence state |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Active-low pause of the serial sequence |
| wp_n | input | 1 | Active-low write protect guarding the lock bit |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |

## Verification
The bench uses the default parameters: three address bytes, identity bytes 0xBF and 0x49, writable status mask 0x8C and the lock at bit 7. At these settings the whole 8-bit opcode space and every possible status data byte are small enough to sweep completely. The identity stream is swept over all eight low-address values in both clock idle levels and above three upper-address patterns, one of which crosses the all-ones wrap. The four combinations of write-protect and lock level are each exercised. Hold pauses are placed inside a read data byte and inside a write data byte, with extra clock edges and flipped input bits applied during the pause.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_IDRD,
    PH_SRRD,
    PH_SRWR,
    PH_IGN
  } phase_t;

  localparam logic [7:0] OPC_ID_READ  = 8'h90;
  localparam logic [7:0] OPC_SR_READ  = 8'h05;
  localparam logic [7:0] OPC_SR_WRITE = 8'h01;

  // Map a completed opcode byte onto the phase that follows it.
  function automatic phase_t decode_opcode(input logic [7:0] op);
    case (op)
      OPC_ID_READ:  return PH_ADDR;
      OPC_SR_READ:  return PH_SRRD;
      OPC_SR_WRITE: return PH_SRWR;
      default:      return PH_IGN;
    endcase
  endfunction

  // Identity byte for the current address parity.
  function automatic logic [7:0] pick_id(input logic lsb,
                                         input logic [7:0] even_id,
                                         input logic [7:0] odd_id);
    return lsb ? odd_id : even_id;
  endfunction

  // Status after a completed write attempt.
  function automatic logic [7:0] next_status(input logic [7:0] cur,
                                             input logic [7:0] data,
                                             input logic       wp_n,
                                             input logic [7:0] mask,
                                             input int         lock_bit);
    if (!wp_n && cur[lock_bit]) return cur;
    return data & mask;
  endfunction

  // Bit slot to present for a given count of bits already clocked.
  function automatic logic [2:0] bit_slot(input logic [2:0] cnt);
    return 3'd7 - cnt;
  endfunction

  function automatic logic is_read_phase(input phase_t ph);
    return (ph == PH_IDRD) || (ph == PH_SRRD);
  endfunction

endpackage

// File: rtl/spi_id_rx.sv
module spi_id_rx
  import spi_id_pkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic       sck,
  input  logic       clr,
  input  logic       si,
  input  logic       hold_n,
  output phase_t     phase,
  output logic [2:0] bit_cnt,
  output logic       addr_lsb,
  output logic       wr_fire,
  output logic [7:0] wr_byte
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int ACNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(ADDR_BYTES - 1);

  logic [6:0]        shreg;
  logic [ADDR_W-1:0] addr;
  logic [ACNT_W-1:0] acnt;
  logic [1:0]        edge_seen;
  logic              byte_end;
  logic [7:0]        nb;

  assign byte_end = (bit_cnt == 3'd7);
  assign nb       = {shreg, si};
  assign wr_byte  = nb;
  assign wr_fire  = hold_n && byte_end && (phase == PH_SRWR);
  assign addr_lsb = addr[0];

  always_ff @(posedge sck or posedge clr) begin
    if (clr) begin
      phase     <= PH_OPC;
      bit_cnt   <= '0;
      shreg     <= '0;
      addr      <= '0;
      acnt      <= '0;
      edge_seen <= '0;
    end else begin
      if (edge_seen != 2'd2) edge_seen <= edge_seen + 2'd1;
      if (hold_n) begin
        bit_cnt <= bit_cnt + 3'd1;
        shreg   <= nb[6:0];
        if (byte_end) begin
          case (phase)
            PH_OPC: begin
              phase <= decode_opcode(nb);
              acnt  <= '0;
            end
            PH_ADDR: begin
              addr <= (addr << 8) | ADDR_W'(nb);
              if (acnt == ACNT_LAST) phase <= PH_IDRD;
              else acnt <= ACNT_W'(acnt + ACNT_W'(1));
            end
            PH_IDRD: addr  <= addr + ADDR_W'(1);
            PH_SRWR: phase <= PH_IGN;
            default: ;
          endcase
        end
      end
    end
  end

  // R1: every unpaused edge advances the bit counter by exactly one
  a_r1_bit_advance: assert property (@(posedge sck) disable iff (clr)
    (edge_seen == 2'd2 && $past(hold_n)) |-> bit_cnt == 3'($past(bit_cnt) + 3'd1));

  // R5: an edge taken while paused leaves the sequence state untouched
  a_r5_hold_freeze: assert property (@(posedge sck) disable iff (clr)
    (edge_seen == 2'd2 && !$past(hold_n)) |->
      ($stable(bit_cnt) && $stable(phase) && $stable(addr)));

endmodule

// File: rtl/spi_id_status.sv
module spi_id_status
  import spi_id_pkg::*;
#(
  parameter logic [7:0] SR_MASK  = 8'h8C,
  parameter int         LOCK_BIT = 7
) (
  input  logic       sck,
  input  logic       rst_n,
  input  logic       wp_n,
  input  logic       wr_fire,
  input  logic [7:0] wr_byte,
  output logic [7:0] status
);
  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else if (wr_fire) status <= next_status(status, wr_byte, wp_n, SR_MASK, LOCK_BIT);
  end

  // R8: a locked status under an active write protect cannot move
  a_r8_lock_guard: assert property (@(posedge sck) disable iff (!rst_n)
    (!wp_n && status[LOCK_BIT]) |=> $stable(status));

endmodule

// File: rtl/spi_id_tx.sv
module spi_id_tx
  import spi_id_pkg::*;
(
  input  logic       sck,
  input  logic       clr,
  input  logic       hold_n,
  input  phase_t     phase,
  input  logic [2:0] bit_cnt,
  input  logic [7:0] tx_byte,
  output logic       so_bit,
  output logic       so_live
);
  always_ff @(negedge sck or posedge clr) begin
    if (clr) begin
      so_bit  <= 1'b0;
      so_live <= 1'b0;
    end else if (hold_n && is_read_phase(phase)) begin
      so_bit  <= tx_byte[bit_slot(bit_cnt)];
      so_live <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_id_slave.sv
module spi_id_slave
  import spi_id_pkg::*;
#(
  parameter int         ADDR_BYTES = 3,
  parameter logic [7:0] EVEN_ID    = 8'hBF,
  parameter logic [7:0] ODD_ID     = 8'h49,
  parameter logic [7:0] SR_MASK    = 8'h8C,
  parameter int         LOCK_BIT   = 7
) (
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  logic       clr;
  phase_t     phase;
  logic [2:0] bit_cnt;
  logic       addr_lsb;
  logic       wr_fire;
  logic [7:0] wr_byte;
  logic [7:0] status;
  logic [7:0] tx_byte;
  logic       so_live;

  assign clr = !rst_n || cs_n;

  spi_id_rx #(.ADDR_BYTES(ADDR_BYTES)) u_rx (
    .sck(sck), .clr(clr), .si(si), .hold_n(hold_n),
    .phase(phase), .bit_cnt(bit_cnt), .addr_lsb(addr_lsb),
    .wr_fire(wr_fire), .wr_byte(wr_byte)
  );

  spi_id_status #(.SR_MASK(SR_MASK), .LOCK_BIT(LOCK_BIT)) u_status (
    .sck(sck), .rst_n(rst_n), .wp_n(wp_n),
    .wr_fire(wr_fire), .wr_byte(wr_byte), .status(status)
  );

  assign tx_byte = (phase == PH_SRRD) ? status : pick_id(addr_lsb, EVEN_ID, ODD_ID);

  spi_id_tx u_tx (
    .sck(sck), .clr(clr), .hold_n(hold_n), .phase(phase),
    .bit_cnt(bit_cnt), .tx_byte(tx_byte), .so_bit(so), .so_live(so_live)
  );

  assign so_oe = so_live && hold_n && !cs_n;

  // R9: an unrecognised command never turns the output driver on
  a_r9_ignore_silent: assert property (@(posedge sck) disable iff (!rst_n)
    (phase == PH_IGN) |-> !so_oe);

endmodule

// File: tb/spi_id_slave_bench.sv
`timescale 1ns/1ps
module spi_id_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  int total = 0, bad = 0;
  logic m3 = 1'b0;
  logic [7:0] rxb;
  logic [7:0] cur_sr = 8'h00;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_id_slave u_spi_id_slave (
    .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  task automatic clk_wait(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sel();
    sck = m3;
    clk_wait(1);
    cs_n = 1'b0;
    clk_wait(1);
  endtask

  task automatic desel();
    clk_wait(1);
    cs_n = 1'b1;
    clk_wait(2);
    chk("R4 quiet when deselected", so_oe, 1'b0);
  endtask

  task automatic sck_bit(input logic b, output logic r, output logic oe);
    if (m3) begin sck = 1'b0; clk_wait(1); end
    si = b;
    clk_wait(1);
    r  = so;
    oe = so_oe;
    sck = 1'b1;
    clk_wait(1);
    if (!m3) begin sck = 1'b0; clk_wait(1); end
  endtask

  task automatic xbyte(input logic [7:0] b, input logic want_oe, input string tag);
    logic r, oe, oe_ok;
    oe_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sck_bit(b[i], r, oe);
      rxb[i] = r;
      if (oe !== want_oe) oe_ok = 1'b0;
    end
    chk(tag, oe_ok, 1'b1);
  endtask

  task automatic rd_status(input logic [7:0] exp, input string tag);
    sel();
    xbyte(8'h05, 1'b0, "R4 opcode quiet");
    xbyte(8'h00, 1'b1, tag);
    chk(tag, rxb, exp);
    xbyte(8'h3C, 1'b1, tag);
    chk(tag, rxb, exp);
    desel();
  endtask

  // Bench model of a completed write: lock is bit 7, protect bits are 3:2.
  task automatic model_write(input logic [7:0] v);
    if (wp_n || !cur_sr[7]) cur_sr = {v[7], 3'b000, v[3:2], 2'b00};
  endtask

  task automatic wr_status(input logic [7:0] v);
    sel();
    xbyte(8'h01, 1'b0, "R4 opcode quiet");
    xbyte(v, 1'b0, "R6 write byte quiet");
    desel();
    model_write(v);
  endtask

  task automatic id_read(input logic [23:0] a, input int nbytes, input string tag);
    logic [23:0] cur;
    sel();
    xbyte(8'h90, 1'b0, "R4 opcode quiet");
    xbyte(a[23:16], 1'b0, "R4 address quiet");
    xbyte(a[15:8],  1'b0, "R4 address quiet");
    xbyte(a[7:0],   1'b0, "R4 address quiet");
    for (int k = 0; k < nbytes; k++) begin
      cur = a + 24'(k);
      xbyte(8'hA5, 1'b1, tag);
      chk(tag, rxb, (cur % 2 == 1) ? 8'h49 : 8'hBF);
    end
    desel();
  endtask

  initial begin
    clk_wait(180000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic r, oe;
    logic [7:0] acc;
    logic [23:0] hi_pat [3];
    hi_pat[0] = 24'h000000;
    hi_pat[1] = 24'hA5C3F0;
    hi_pat[2] = 24'hFFFFF8;

    // R11: reset state
    clk_wait(3);
    chk("R11 output off in reset", so_oe, 1'b0);
    rst_n = 1'b1;
    clk_wait(2);
    rd_status(8'h00, "R11 status after reset");

    // R1 R2: identity stream, both idle levels, low address sweep with wrap
    for (int m = 0; m < 2; m++) begin
      m3 = m[0];
      for (int h = 0; h < 3; h++)
        for (int lo = 0; lo < 8; lo++)
          id_read(hi_pat[h] | 24'(lo), 4 + lo % 3, m3 ? "R1 R2 id idle-high" : "R1 R2 id idle-low");
    end
    m3 = 1'b0;

    // R5: pause inside a read data byte; pending bit is bit 6 of 0xBF (0)
    sel();
    xbyte(8'h90, 1'b0, "R4 opcode quiet");
    xbyte(8'h00, 1'b0, "R4 address quiet");
    xbyte(8'h00, 1'b0, "R4 address quiet");
    xbyte(8'h00, 1'b0, "R4 address quiet");
    sck_bit(1'b0, r, oe);
    chk("R5 first bit before hold", {oe, r}, 2'b11);
    hold_n = 1'b0;
    clk_wait(1);
    chk("R5 output off in hold", so_oe, 1'b0);
    repeat (3) begin
      si = ~si; sck = 1'b1; clk_wait(1); sck = 1'b0; clk_wait(1);
    end
    hold_n = 1'b1;
    clk_wait(1);
    chk("R5 output back after hold", so_oe, 1'b1);
    chk("R5 pending bit after hold", so, 1'b0);
    acc = 8'h80;
    for (int i = 6; i >= 0; i--) begin
      sck_bit(1'b0, r, oe);
      acc[i] = r;
    end
    chk("R5 byte across hold", acc, 8'hBF);
    xbyte(8'h00, 1'b1, "R5 next byte");
    chk("R5 next byte", rxb, 8'h49);
    desel();

    // R5: pause inside a write data byte with flipped input bits
    wp_n = 1'b1;
    sel();
    xbyte(8'h01, 1'b0, "R4 opcode quiet");
    for (int i = 7; i >= 4; i--) sck_bit(acc_bit(8'h84, i), r, oe);
    hold_n = 1'b0;
    clk_wait(1);
    repeat (4) begin
      si = 1'b1; sck = 1'b1; clk_wait(1); sck = 1'b0; clk_wait(1);
    end
    hold_n = 1'b1;
    clk_wait(1);
    for (int i = 3; i >= 0; i--) sck_bit(acc_bit(8'h84, i), r, oe);
    desel();
    model_write(8'h84);
    rd_status(cur_sr, "R5 write across hold");

    // R6: only the first data byte counts
    sel();
    xbyte(8'h01, 1'b0, "R4 opcode quiet");
    xbyte(8'h0C, 1'b0, "R6 write byte quiet");
    xbyte(8'h88, 1'b0, "R6 extra byte quiet");
    desel();
    model_write(8'h0C);
    rd_status(cur_sr, "R6 extra byte ignored");

    // R3 R6: every data byte, alternating idle level
    for (int v = 0; v < 256; v++) begin
      m3 = v[0];
      wr_status(8'(v));
      rd_status(cur_sr, "R3 R6 status sweep");
    end
    m3 = 1'b0;

    // R8: protect pin and lock combinations
    wp_n = 1'b1; wr_status(8'h80); rd_status(cur_sr, "R8 lock set with pin high");
    wp_n = 1'b0; wr_status(8'h0C); rd_status(8'h80, "R8 locked write ignored");
    wr_status(8'h00); rd_status(8'h80, "R8 locked clear ignored");
    wp_n = 1'b1; wr_status(8'h08); rd_status(8'h08, "R8 pin high overrides lock");
    wp_n = 1'b0; wr_status(8'h84); rd_status(8'h84, "R8 unlocked write accepted");
    wr_status(8'h00); rd_status(8'h84, "R8 newly locked");
    wp_n = 1'b1; wr_status(8'h0C); rd_status(8'h0C, "R8 unlock again");

    // R7: data byte cut short
    for (int n = 1; n < 8; n += 3) begin
      sel();
      xbyte(8'h01, 1'b0, "R4 opcode quiet");
      for (int i = 0; i < n; i++) sck_bit(1'b1, r, oe);
      desel();
      rd_status(8'h0C, "R7 partial write ignored");
    end

    // R10: aborts at several points
    sel(); xbyte(8'h90, 1'b0, "R4 opcode quiet");
    for (int i = 0; i < 5; i++) sck_bit(1'b1, r, oe);
    desel();
    rd_status(8'h0C, "R10 abort in address");
    sel();
    for (int i = 0; i < 3; i++) sck_bit(1'b0, r, oe);
    desel();
    rd_status(8'h0C, "R10 abort in opcode");
    sel(); xbyte(8'h05, 1'b0, "R4 opcode quiet");
    for (int i = 0; i < 4; i++) sck_bit(1'b0, r, oe);
    desel();
    id_read(24'h000001, 2, "R10 abort in read data");

    // R9: every unrecognised opcode
    wp_n = 1'b1;
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h90 || op == 8'h05 || op == 8'h01) continue;
      sel();
      xbyte(8'(op), 1'b0, "R9 unknown opcode silent");
      xbyte(8'h01, 1'b0, "R9 trailing byte silent");
      xbyte(8'hFF, 1'b0, "R9 trailing byte silent");
      desel();
    end
    rd_status(8'h0C, "R9 status untouched");

    // R11: reset in the middle of operation clears status
    rst_n = 1'b0;
    clk_wait(2);
    chk("R11 output off in reset", so_oe, 1'b0);
    rst_n = 1'b1;
    clk_wait(2);
    cur_sr = 8'h00;
    rd_status(8'h00, "R11 status cleared by reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic acc_bit(input logic [7:0] v, input int i);
    return v[i];
  endfunction

endmodule